// File: doc/BRIEF.md
# Post-trigger sample capture controller

The block records a four-bit channel input into a 256-word by 8-bit synchronous memory after a trigger pulse arrives. Sampling runs on a selected sample tick. The tick comes either from an internal divider of the system clock or from rising edges of an external sample clock, which is synchronised first. For each stored sample, a write sequencer steps through three states: idle, then chip-enable, then write strobe. It moves one state per tick, so the block stores one sample every three ticks. The write address starts at zero and advances once per stored sample.

The capture stops after the last address has been written, and a ready flag rises. A host then sets read mode and pulses a read strobe with an address, and the stored word appears one cycle later. Trigger pulses are ignored while a capture is running or after ready is set. Only a reset rearms the block.

Top module: `post_trig_capture`

## Requirements
- R1: While rst_ni is low and just after it rises, ready_o, ce_o and we_o are 0 and rd_data_o is 0.
- R2: Before the first trigger pulse, ce_o and we_o stay 0 and nothing is written.
- R3: After a trigger, each sample takes three states (idle, ce_o high, we_o high). The state changes only on a selected tick, so ce_o and we_o are never high together and one sample is stored per three ticks.
- R4: The word stored for a sample is {4'b0000, ch_i}, with the channel bits in bits 3:0 and zeros in bits 7:4. ch_i is taken in the cycle where the strobe state sees a tick. The first sample goes to address 0 and each later sample goes to the next address.
- R5: Once address 255 has been written, ready_o goes high and stays high until reset, and ce_o and we_o stay 0.
- R6: With sel_int_i = 1, a tick occurs every INT_DIV clock cycles from a counter that runs freely from reset. With sel_int_i = 0, a tick occurs on each rising edge of ext_clk_i, seen after a two-flop synchroniser. With sel_int_i = 0 and ext_clk_i held still, the sequencer does not advance.
- R7: A trigger pulse during a capture or after ready_o does not restart or extend it, so exactly 256 write strobes occur per capture.
- R8: When ready_o, rd_mode_i and rd_stb_i are all 1 at a clock edge, rd_data_o shows the word at rd_addr_i from that edge on. Otherwise rd_data_o holds its value, including before ready.
- R9: A reset in the middle of a capture or after it clears ready_o and stops the strobes. The next trigger starts a new capture at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_int_i | input | 1 | 1: internal divided tick, 0: external sample clock |
| ext_clk_i | input | 1 | External sample clock, asynchronous |
| trig_i | input | 1 | Capture trigger |
| ch_i | input | 4 | Channel inputs |
| rd_mode_i | input | 1 | Routes rd_addr_i to the memory after ready |
| rd_stb_i | input | 1 | Host read strobe |
| rd_addr_i | input | 8 | Host read address |
| ce_o | output | 1 | Chip-enable state of the write sequence |
| we_o | output | 1 | Write-strobe state of the write sequence |
| ready_o | output | 1 | Capture complete |
| rd_data_o | output | 8 | Registered read data |

## Verification
The checker tests four things on every cycle: ce and strobe never overlap, a strobe is always preceded by chip-enable, the sequencer holds its state between ticks, and the address steps by one per write. It also checks that ready rises only after the last address is written, stays high and silences the strobes, and that the read data moves only on a qualified read. Some behaviour can only be shown by the bench scenarios: which channel value ends up in which word, the zero upper nibble, the exact tick rate in each clock mode, and that late triggers are ignored. The bench shows these by reading back whole captures and by comparing the strobe outputs against a behavioural model on every clock.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {PH_ARMED, PH_RUN, PH_DONE} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CE, ST_WR} step_e;
endpackage

// File: rtl/ptc_tick_gen.sv
module ptc_tick_gen #(
  parameter int INT_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_int_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int DW = (INT_DIV < 2) ? 1 : $clog2(INT_DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    sync_q;
  logic          int_tick, ext_tick;

  assign int_tick = (div_q == DIV_LAST);
  // rising edge after two synchroniser stages
  assign ext_tick = sync_q[1] & ~sync_q[2];
  assign tick_o   = sel_int_i ? int_tick : ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= int_tick ? '0 : div_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_clk_i};
    end
  end
endmodule

// File: rtl/ptc_write_ctrl.sv
module ptc_write_ctrl
  import ptc_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          trig_i,
  output logic          ce_o,
  output logic          we_o,
  output logic          ready_o,
  output logic          mem_we_o,
  output logic [AW-1:0] wr_addr_o
);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

  phase_e        phase_q;
  step_e         step_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ARMED;
      step_q  <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      case (phase_q)
        PH_ARMED: if (trig_i) begin
          phase_q <= PH_RUN;
          step_q  <= ST_IDLE;
          addr_q  <= '0;
        end
        PH_RUN: if (tick_i) begin
          case (step_q)
            ST_IDLE: step_q <= ST_CE;
            ST_CE:   step_q <= ST_WR;
            ST_WR: begin
              step_q <= ST_IDLE;
              if (addr_q == ADDR_LAST) phase_q <= PH_DONE;
              else                     addr_q  <= addr_q + 1'b1;
            end
            default: step_q <= ST_IDLE;
          endcase
        end
        PH_DONE: ;
        default: phase_q <= PH_ARMED;
      endcase
    end
  end

  assign ce_o      = (phase_q == PH_RUN) && (step_q == ST_CE);
  assign we_o      = (phase_q == PH_RUN) && (step_q == ST_WR);
  assign mem_we_o  = we_o && tick_i;
  assign ready_o   = (phase_q == PH_DONE);
  assign wr_addr_o = addr_q;
endmodule

// File: rtl/ptc_sample_ram.sv
module ptc_sample_ram #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/post_trig_capture.sv
module post_trig_capture #(
  parameter int CH_W    = 4,
  parameter int WORD_W  = 8,
  parameter int DEPTH   = 256,
  parameter int INT_DIV = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_int_i,
  input  logic              ext_clk_i,
  input  logic              trig_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              rd_mode_i,
  input  logic              rd_stb_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              ce_o,
  output logic              we_o,
  output logic              ready_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic              tick, mem_we, rd_sel, rd_en;
  logic [AW-1:0]     wr_addr, ram_addr;
  logic [WORD_W-1:0] wdata;

  ptc_tick_gen #(.INT_DIV(INT_DIV)) u_tick (
    .clk_i, .rst_ni, .sel_int_i, .ext_clk_i, .tick_o(tick)
  );

  ptc_write_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .tick_i(tick), .trig_i,
    .ce_o, .we_o, .ready_o, .mem_we_o(mem_we), .wr_addr_o(wr_addr)
  );

  generate
    if (WORD_W > CH_W) begin : g_pad
      assign wdata = {{(WORD_W-CH_W){1'b0}}, ch_i};
    end else begin : g_nopad
      assign wdata = ch_i[WORD_W-1:0];
    end
  endgenerate

  assign rd_sel   = ready_o && rd_mode_i;
  assign rd_en    = rd_sel && rd_stb_i;
  assign ram_addr = rd_sel ? rd_addr_i : wr_addr;

  ptc_sample_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
    .clk_i, .rst_ni, .addr_i(ram_addr), .we_i(mem_we), .wdata_i(wdata),
    .re_i(rd_en), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              mem_we,
  input logic [AW-1:0]     wr_addr,
  input logic              ce_o,
  input logic              we_o,
  input logic              ready_o,
  input logic              rd_mode_i,
  input logic              rd_stb_i,
  input logic [WORD_W-1:0] rd_data_o
);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && we_o));
  a_r3_we_after_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> $past(ce_o));
  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_o) && !$past(tick)) |-> ce_o);
  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_we) && !ready_o) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));
  a_r5_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(mem_we) && $past(wr_addr) == ADDR_LAST));
  a_r5_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r5_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!ce_o && !we_o));
  a_r8_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ready_o && rd_mode_i && rd_stb_i) |-> $stable(rd_data_o));
endmodule

bind post_trig_capture ptc_checker #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_chk (
  .clk_i, .rst_ni, .tick, .mem_we, .wr_addr, .ce_o, .we_o, .ready_o,
  .rd_mode_i, .rd_stb_i, .rd_data_o
);

// File: tb/post_trig_capture_test.sv
`timescale 1ns/1ps
module post_trig_capture_test;
  localparam int DEPTH = 256;
  localparam int DIV   = 3;

  logic clk = 0, rst_n = 0, sel = 1, ext_clk = 0, trig = 0;
  logic [3:0] ch = 0;
  logic rd_mode = 0, rd_stb = 0;
  logic [7:0] rd_addr = 0;
  logic ce, we, ready;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0, we_rises = 0;
  bit ext_en = 0, we_prev = 0;

  // model state
  int divc, m_phase, m_step, m_addr;
  bit s0, s1, s2;
  logic [7:0] exp_mem [DEPTH];

  post_trig_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_int_i(sel), .ext_clk_i(ext_clk),
    .trig_i(trig), .ch_i(ch), .rd_mode_i(rd_mode), .rd_stb_i(rd_stb),
    .rd_addr_i(rd_addr), .ce_o(ce), .we_o(we), .ready_o(ready),
    .rd_data_o(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divc = 0; s0 = 0; s1 = 0; s2 = 0;
      m_phase = 0; m_step = 0; m_addr = 0;
    end else begin
      bit itick, etick, tk;
      itick = (divc == DIV - 1);
      etick = s1 && !s2;
      tk = sel ? itick : etick;
      s2 = s1; s1 = s0; s0 = ext_clk;
      divc = itick ? 0 : divc + 1;
      if (m_phase == 0) begin
        if (trig) begin m_phase = 1; m_step = 0; m_addr = 0; end
      end else if (m_phase == 1 && tk) begin
        if (m_step == 2) begin
          exp_mem[m_addr] = {4'b0000, ch};
          m_step = 0;
          if (m_addr == DEPTH - 1) m_phase = 2;
          else m_addr++;
        end else m_step++;
      end
    end
  end

  // per-cycle compare and stimulus helpers at negedge
  always @(negedge clk) begin
    cyc++;
    ch = 4'((cyc * 7 + 3) ^ (cyc >> 4));
    if (we && !we_prev) we_rises++;
    we_prev = we;
    if (rst_n) begin
      chk("R3 ce_o", ce, (m_phase == 1 && m_step == 1));
      chk("R3 we_o", we, (m_phase == 1 && m_step == 2));
      chk("R5 ready_o", ready, (m_phase == 2));
    end
  end

  initial forever begin
    repeat (2) @(negedge clk);
    if (ext_en) ext_clk = ~ext_clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic fire();
    trig = 1; we_rises = 0;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic read_word(int a, string tag);
    rd_addr = 8'(a); rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chk(tag, rd_data, exp_mem[a]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", ready, 0);
    chk("R1 ce in reset", ce, 0);
    chk("R1 we in reset", we, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 0);

    // read attempt before ready has no effect
    rd_mode = 1; rd_addr = 5; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; rd_mode = 0;
    @(negedge clk);
    chk("R8 no read before ready", rd_data, 0);

    repeat (50) @(negedge clk);
    chk("R2 no strobes while armed", we_rises, 0);
    chk("R2 ce low while armed", ce, 0);

    // internal-tick capture with stray triggers
    fire();
    repeat (100) @(negedge clk);
    trig = 1; @(negedge clk); trig = 0;
    repeat (400) @(negedge clk);
    trig = 1; @(negedge clk); trig = 0;
    wait_ready();
    chk("R7 strobe count", we_rises, DEPTH);
    trig = 1; @(negedge clk); trig = 0;
    repeat (30) @(negedge clk);
    chk("R7 ready after late trigger", ready, 1);
    chk("R7 no strobes after late trigger", we_rises, DEPTH);

    rd_mode = 1;
    for (int a = 0; a < DEPTH; a++) read_word(a, "R4 readback");
    read_word(0, "R4 first sample at address 0");
    chk("R4 upper nibble zero", rd_data[7:4], 0);

    // strobe without read mode leaves data unchanged
    rd_mode = 0; rd_addr = 8'd17; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chk("R8 hold without read mode", rd_data, exp_mem[0]);
    rd_mode = 1; rd_addr = 8'd18;
    repeat (2) @(negedge clk);
    chk("R8 hold without strobe", rd_data, exp_mem[0]);
    rd_mode = 0;

    // reset after capture, then external clock capture
    rst_n = 0;
    @(negedge clk);
    chk("R9 ready cleared", ready, 0);
    rst_n = 1; sel = 0; ext_en = 1;
    repeat (5) @(negedge clk);
    fire();
    wait_ready();
    chk("R6 external strobe count", we_rises, DEPTH);
    rd_mode = 1;
    for (int a = 0; a < DEPTH; a++) read_word(a, "R6 external readback");
    rd_mode = 0;

    // external clock stalled: no progress
    rst_n = 0; ext_en = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    fire();
    repeat (40) @(negedge clk);
    chk("R6 stalled ce", ce, 0);
    chk("R6 stalled we", we_rises, 0);
    ext_en = 1;
    repeat (60) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R9 mid-run reset ready", ready, 0);
    chk("R9 mid-run reset ce", ce, 0);
    chk("R9 mid-run reset we", we, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end
endmodule